// File: doc/BRIEF.md
# Two-Street Traffic Light Controller

This block runs the lights at a crossing of two streets, A and B, as a Moore state machine with four states. Each street has a car sensor that reads high while traffic is waiting or passing. A street keeps its green for as long as its sensor stays high. When the sensor drops, the light goes to yellow, then to red, and the other street turns green. Each street has a 2-bit light code output, and that code is decoded only from the registered state.

Two parameters shape the timing. `YELLOW_CYCLES` sets how many clock cycles each yellow lasts. `MIN_GREEN` sets the shortest time a green may be shown, even when its sensor is already low. The lights change on the clock edge that changes the state, so a change on a sensor shows on the lights one cycle later.

Top module: `traffic_xing_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, street A shows green (00) and street B shows red (10). Reset is asynchronous and active high.
- R2: The light codes are green=00, yellow=01 and red=10. The code 11 never appears, and in every cycle at least one street shows red.
- R3: While A shows green and `car_a` is high at a rising edge, A is still green after that edge.
- R4: A green lasts at least `MIN_GREEN` cycles, even when its sensor is low for the whole time.
- R5: Once a green has lasted `MIN_GREEN` cycles, a low sensor at a rising edge turns that street yellow at that same edge. The change is seen on the lights one cycle after the sensor falls.
- R6: Each yellow lasts exactly `YELLOW_CYCLES` cycles, whatever the sensors show. After that, the yellow street turns red and the other street turns green.
- R7: The lights always follow this order: A green, A yellow, B green, B yellow, then A green again.
- R8: While B shows green and `car_b` is high at a rising edge, B is still green after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| car_a | input | 1 | Street A sensor; high while cars are present |
| car_b | input | 1 | Street B sensor; high while cars are present |
| light_a | output | 2 | Street A light: 00 green, 01 yellow, 10 red |
| light_b | output | 2 | Street B light: 00 green, 01 yellow, 10 red |

## Verification
The assertions assume that both sensors are synchronous to `clk` and stable around the rising edge. They also assume that both parameters are at least one. The checker measures how long the lights have shown their current pair of codes with its own age counter, which starts from a value that is known at reset. The bench changes the sensors only on the falling edge and leaves the parameters at their defaults. This keeps every sensor value settled and known when the state register samples it.

// File: rtl/traffic_xing_ctrl.sv
module traffic_xing_ctrl #(
  parameter int YELLOW_CYCLES = 3,
  parameter int MIN_GREEN     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       car_a,
  input  logic       car_b,
  output logic [1:0] light_a,
  output logic [1:0] light_b
);
  localparam int CMAX = (YELLOW_CYCLES > MIN_GREEN) ? YELLOW_CYCLES : MIN_GREEN;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] YLAST = CW'(YELLOW_CYCLES - 1);
  localparam logic [CW-1:0] GLAST = CW'(MIN_GREEN - 1);
  localparam logic [CW-1:0] CTOP  = CW'(CMAX - 1);

  logic [1:0]    st, st_nx;
  logic [CW-1:0] cnt;

  wire green_done  = cnt >= GLAST;
  wire yellow_done = cnt == YLAST;

  always_comb begin
    st_nx = st;
    case (st)
      2'b00: if (!car_a && green_done) st_nx = 2'b01;
      2'b01: if (yellow_done)          st_nx = 2'b10;
      2'b10: if (!car_b && green_done) st_nx = 2'b11;
      2'b11: if (yellow_done)          st_nx = 2'b00;
      default: st_nx = 2'b00;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      st  <= 2'b00;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st)     cnt <= '0;
      else if (cnt < CTOP) cnt <= cnt + 1'b1;
    end
  end

  assign light_a = {st[1], ~st[1] & st[0]};
  assign light_b = {~st[1], st[1] & st[0]};
endmodule

// File: rtl/traffic_xing_chk.sv
module traffic_xing_chk #(
  parameter int YELLOW_CYCLES = 3,
  parameter int MIN_GREEN     = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       car_a,
  input logic       car_b,
  input logic [1:0] light_a,
  input logic [1:0] light_b
);
  localparam int CMAX = (YELLOW_CYCLES > MIN_GREEN) ? YELLOW_CYCLES : MIN_GREEN;
  localparam int AW   = $clog2(CMAX + 2);
  localparam logic [AW-1:0] YL = AW'(YELLOW_CYCLES - 1);
  localparam logic [AW-1:0] GL = AW'(MIN_GREEN - 1);
  localparam logic [AW-1:0] CAP = AW'(CMAX);

  logic [3:0]    prev_q;
  logic [AW-1:0] age_q, age;

  assign age = ({light_a, light_b} == prev_q) ? ((age_q < CAP) ? age_q + 1'b1 : CAP) : '0;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev_q <= 4'b1111;
      age_q  <= '0;
    end else begin
      prev_q <= {light_a, light_b};
      age_q  <= age;
    end
  end

  p_no_code11_r2: assert property (@(posedge clk) disable iff (rst)
    light_a != 2'b11 && light_b != 2'b11);
  p_one_red_r2: assert property (@(posedge clk) disable iff (rst)
    light_a == 2'b10 || light_b == 2'b10);
  p_hold_a_r3: assert property (@(posedge clk) disable iff (rst)
    (light_a == 2'b00 && car_a) |=> light_a == 2'b00);
  p_hold_b_r8: assert property (@(posedge clk) disable iff (rst)
    (light_b == 2'b00 && car_b) |=> light_b == 2'b00);
  p_min_green_a_r4: assert property (@(posedge clk) disable iff (rst)
    (light_a == 2'b00 && age < GL) |=> light_a == 2'b00);
  p_min_green_b_r4: assert property (@(posedge clk) disable iff (rst)
    (light_b == 2'b00 && age < GL) |=> light_b == 2'b00);
  p_leave_a_r5: assert property (@(posedge clk) disable iff (rst)
    (light_a == 2'b00 && age >= GL && !car_a) |=> light_a == 2'b01);
  p_yellow_len_a_r6: assert property (@(posedge clk) disable iff (rst)
    (light_a == 2'b01 && age < YL) |=> light_a == 2'b01);
  p_yellow_end_a_r6: assert property (@(posedge clk) disable iff (rst)
    (light_a == 2'b01 && age == YL) |=> (light_a == 2'b10 && light_b == 2'b00));
  p_yellow_end_b_r6: assert property (@(posedge clk) disable iff (rst)
    (light_b == 2'b01 && age == YL) |=> (light_b == 2'b10 && light_a == 2'b00));
  p_order_a_r7: assert property (@(posedge clk) disable iff (rst)
    (light_a == 2'b00) |=> (light_a == 2'b00 || light_a == 2'b01));
  p_order_b_r7: assert property (@(posedge clk) disable iff (rst)
    (light_b == 2'b00) |=> (light_b == 2'b00 || light_b == 2'b01));
endmodule

bind traffic_xing_ctrl traffic_xing_chk #(
  .YELLOW_CYCLES(YELLOW_CYCLES),
  .MIN_GREEN(MIN_GREEN)
) chk_i (
  .clk(clk), .rst(rst), .car_a(car_a), .car_b(car_b),
  .light_a(light_a), .light_b(light_b)
);

// File: tb/traffic_xing_ctrl_tb_top.sv
module traffic_xing_ctrl_tb_top;
  localparam int YC = 3;
  localparam int MG = 4;
  localparam logic [1:0] GRN = 2'b00, YEL = 2'b01, RED = 2'b10;

  logic clk = 1'b0, rst = 1'b1, car_a = 1'b0, car_b = 1'b0;
  logic [1:0] light_a, light_b;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  traffic_xing_ctrl #(.YELLOW_CYCLES(YC), .MIN_GREEN(MG)) dut_i (
    .clk(clk), .rst(rst), .car_a(car_a), .car_b(car_b),
    .light_a(light_a), .light_b(light_b));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: lights a/b act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pair(input string tag, input logic [1:0] ea, input logic [1:0] eb);
    chk({light_a, light_b} == {ea, eb}, tag, {light_a, light_b}, {ea, eb});
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    chk(light_a != 2'b11 && light_b != 2'b11 && (light_a == RED || light_b == RED),
        "R2 code/conflict", {light_a, light_b}, 4'b1010);
  endtask

  task automatic t_reset();
    rst = 1'b1; car_a = 1'b0; car_b = 1'b0;
    #35;
    pair("R1 in reset", GRN, RED);
    @(negedge clk); rst = 1'b0;
    pair("R1 after release", GRN, RED);
  endtask

  task automatic t_min_green_and_cycle();
    for (int i = 1; i < MG; i++) begin
      step(); pair("R4 min green A", GRN, RED);
    end
    step(); pair("R5 A to yellow", YEL, RED);
    car_a = 1'b1; car_b = 1'b1;
    for (int i = 1; i < YC; i++) begin
      step(); pair("R6 A yellow held", YEL, RED);
    end
    step(); pair("R7 B green after A yellow", RED, GRN);
  endtask

  task automatic t_hold_b();
    car_b = 1'b1;
    for (int i = 0; i < 20; i++) begin
      car_a = i[0];
      step(); pair("R8 B held by sensor", RED, GRN);
    end
    car_b = 1'b0;
    step(); pair("R5 B to yellow one cycle later", RED, YEL);
    car_b = 1'b1;
    for (int i = 1; i < YC; i++) begin
      step(); pair("R6 B yellow ignores sensor", RED, YEL);
    end
    car_a = 1'b1;
    step(); pair("R7 A green after B yellow", GRN, RED);
  endtask

  task automatic t_hold_a();
    car_a = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step(); pair("R3 A held by sensor", GRN, RED);
    end
    car_a = 1'b0; car_b = 1'b0;
    step(); pair("R5 A to yellow", YEL, RED);
    for (int i = 1; i < YC; i++) step();
    step(); pair("R7 B green", RED, GRN);
    for (int i = 1; i < MG; i++) begin
      step(); pair("R4 min green B", RED, GRN);
    end
    step(); pair("R5 B yellow after min green", RED, YEL);
  endtask

  task automatic t_reset_midway();
    @(negedge clk); #3 rst = 1'b1; #2;
    pair("R1 async reset from yellow", GRN, RED);
    @(negedge clk); rst = 1'b0;
    pair("R1 released", GRN, RED);
  endtask

  initial begin
    t_reset();
    t_min_green_and_cycle();
    t_hold_b();
    t_hold_a();
    t_reset_midway();
    t_min_green_and_cycle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule